// File: doc/BRIEF.md
# Microstep Stepper Phase Sequencer

This block converts a step clock into excitation commands for a two-winding, four-phase stepper motor. It keeps an electrical position over one full cycle. On each qualifying edge of the step input it moves that position forward or backward by an amount set by the selected excitation mode. From the position it derives four winding-polarity enables, one current amplitude code per winding, and monitor bits that report the active quadrant and whether the position sits on a quadrant origin.

A three-bit mode word selects two things: how finely a quarter cycle is divided (full step, or 2, 4, 8 or 16 positions per quarter) and whether the step input counts rising edges only or both edges. The amplitude codes come from a quarter-wave, cosine-like table. A return input pulls the position back to the origin of its current quadrant. A low enable freezes the block and cuts the winding drive. The step input is synchronized internally. All other inputs are assumed to be clean and synchronous.

The control state machine has two states. SEQ_HOLD is entered on reset and whenever `run_en` is sampled low. SEQ_RUN is entered when `run_en` is sampled high. The transition HOLD→RUN happens on a clock edge with `run_en` high, and RUN→HOLD on a clock edge with `run_en` low. Each state otherwise loops on itself.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_n` is low the position is 0, the state is SEQ_HOLD and all four coil enables are 0. With position 0 in any mode other than full step, `amp_a` is 255, `amp_b` is 0, `quad_mon` is 00 and `off_origin` is 0.
- R2: A change on `step_in` updates the position, and with it the outputs, on the third rising `clk` edge after the change. Two synchronizer stages are followed by the position register.
- R3: If `mode_sel[2]` is 1, only rising edges of `step_in` count as steps. If it is 0, both rising and falling edges count.
- R4: The step size in 1/64-cycle units is selected as follows. With `mode_sel[2]`=1: `mode_sel[1:0]` 00→16 (full), 01→4, 10→8, 11→2. With `mode_sel[2]`=0: 00→8, 01→2, 10→4, 11→1.
- R5: If `dir_fwd` is 1, a step adds the step size to the position. If it is 0, a step subtracts it. Both wrap modulo 64.
- R6: Let q be the position divided by 16 and f be the position modulo 16. T[f] is the 8-bit table 255,255,255,245,235,224,212,197,181,161,140,121,102,77,51,26,0 for f=0..16. The amplitude magnitudes are (A,B) = (T[f],T[16-f]) for q=0 and q=2, and (T[16-f],T[f]) for q=1 and q=3.
- R7: Winding A is positive in q=0 and q=3 and negative in q=1 and q=2. Winding B is positive in q=0 and q=1 and negative in q=2 and q=3. `coil_a_pos`/`coil_a_neg` show A's sign and `coil_b_pos`/`coil_b_neg` show B's sign. A winding with zero amplitude has both of its enables at 0.
- R8: In full-step mode both amplitudes are 255 and both windings are driven, with the signs given in R7.
- R9: `quad_mon` equals q (00 A, 01 B, 10 A-bar, 11 B-bar). `off_origin` is 0 when f=0 and 1 otherwise.
- R10: In SEQ_RUN, `home_req` high sets f to 0 and keeps q on the next edge. It takes priority over a step detected in the same cycle.
- R11: In SEQ_RUN, a position that is not a multiple of the current step size is rounded to the nearest multiple on the next edge, with ties rounding upward, modulo 64.
- R12: When `run_en` is sampled low, from the next edge onward all coil enables are 0. The position and the active mode are frozen, and changes on `step_in`, `home_req` and `mode_sel` have no effect. The amplitude and monitor outputs keep showing the frozen position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = run, 0 = hold with drive cut |
| step_in | input | 1 | Step clock, asynchronous to clk |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| mode_sel | input | 3 | Edge select (bit 2) and granularity (bits 1:0) |
| home_req | input | 1 | Return to quadrant origin |
| coil_a_pos | output | 1 | Winding A driven positive |
| coil_a_neg | output | 1 | Winding A driven negative |
| coil_b_pos | output | 1 | Winding B driven positive |
| coil_b_neg | output | 1 | Winding B driven negative |
| amp_a | output | AMP_W | Winding A amplitude code |
| amp_b | output | AMP_W | Winding B amplitude code |
| quad_mon | output | 2 | Active quadrant |
| off_origin | output | 1 | 0 at a quadrant origin |

## Verification
A detected step and a return request can land on the same clock edge, and R10 decides which one wins. The bench places the position at 31, the last point of quadrant 1, with the direction set forward. It toggles `step_in` and raises `home_req` during exactly the cycle in which the synchronized edge is detected. If the step were taken first the position would move into quadrant 2 and return to 32. The result is judged correct only if the outputs show position 16, the origin of quadrant 1.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int IDX_W  = 6;
    localparam int FRAC_W = 4;
    localparam int FRAC_N = 1 << FRAC_W;

    typedef logic [IDX_W-1:0] idx_t;

    // value is log2 of the step size in 1/64-cycle units
    typedef enum logic [2:0] {
        GR_SIXTEENTH = 3'd0,
        GR_EIGHTH    = 3'd1,
        GR_QUARTER   = 3'd2,
        GR_HALF      = 3'd3,
        GR_FULL      = 3'd4
    } gran_e;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/stp_edge_sync.sv
module stp_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic both_edges,
    output logic pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               synced;
    logic               prior;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], din};
    end

    assign synced = chain_q[SYNC_STAGES-1];
    assign prior  = chain_q[SYNC_STAGES];
    assign pulse  = both_edges ? (synced ^ prior) : (synced & ~prior);
endmodule

// File: rtl/stp_mode_decode.sv
module stp_mode_decode
    import stp_pkg::*;
(
    input  logic [2:0] mode_sel,
    output gran_e      gran,
    output logic       both_edges,
    output logic       full_step
);
    always_comb begin
        unique case (mode_sel)
            3'b100: gran = GR_FULL;
            3'b101: gran = GR_QUARTER;
            3'b110: gran = GR_HALF;
            3'b111: gran = GR_EIGHTH;
            3'b000: gran = GR_HALF;
            3'b001: gran = GR_EIGHTH;
            3'b010: gran = GR_QUARTER;
            3'b011: gran = GR_SIXTEENTH;
        endcase
    end

    assign both_edges = ~mode_sel[2];
    assign full_step  = (gran == GR_FULL);
endmodule

// File: rtl/stp_wave_map.sv
module stp_wave_map
    import stp_pkg::*;
#(
    parameter int AMP_W = 8
) (
    input  idx_t             idx,
    input  logic             full_step,
    input  logic             drive_on,
    output logic             coil_a_pos,
    output logic             coil_a_neg,
    output logic             coil_b_pos,
    output logic             coil_b_neg,
    output logic [AMP_W-1:0] amp_a,
    output logic [AMP_W-1:0] amp_b,
    output logic [1:0]       quad_mon,
    output logic             off_origin
);
    localparam int unsigned AMP_MAX = (1 << AMP_W) - 1;
    localparam logic [FRAC_W:0] QTR_LEN = (FRAC_W+1)'(FRAC_N);

    // winding ratio in percent at eighths of a quarter cycle
    function automatic int unsigned ratio_code(input int unsigned k);
        int unsigned pct;
        case (k)
            0, 1:    pct = 100;
            2:       pct = 92;
            3:       pct = 83;
            4:       pct = 71;
            5:       pct = 55;
            6:       pct = 40;
            7:       pct = 20;
            default: pct = 0;
        endcase
        return (pct * AMP_MAX + 50) / 100;
    endfunction

    function automatic logic [AMP_W-1:0] qwave(input int unsigned f);
        int unsigned lo;
        int unsigned hi;
        lo = ratio_code(f >> 1);
        hi = ratio_code((f >> 1) + 1);
        if ((f % 2) == 0) return AMP_W'(lo);
        return AMP_W'((lo + hi + 1) / 2);
    endfunction

    logic [AMP_W-1:0] rom [FRAC_N+1];

    for (genvar g = 0; g <= FRAC_N; g++) begin : g_rom
        assign rom[g] = qwave(g);
    end

    logic [1:0]        quad;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   lag_sel;
    logic [AMP_W-1:0]  lead;
    logic [AMP_W-1:0]  lag;
    logic [AMP_W-1:0]  mag_a;
    logic [AMP_W-1:0]  mag_b;
    logic              neg_a;
    logic              neg_b;

    assign quad    = idx[IDX_W-1 -: 2];
    assign frac    = idx[FRAC_W-1:0];
    assign lag_sel = QTR_LEN - {1'b0, frac};
    assign lead    = rom[frac];
    assign lag     = rom[lag_sel];

    always_comb begin
        unique case (quad)
            2'd0: begin mag_a = lead; mag_b = lag;  neg_a = 1'b0; neg_b = 1'b0; end
            2'd1: begin mag_a = lag;  mag_b = lead; neg_a = 1'b1; neg_b = 1'b0; end
            2'd2: begin mag_a = lead; mag_b = lag;  neg_a = 1'b1; neg_b = 1'b1; end
            2'd3: begin mag_a = lag;  mag_b = lead; neg_a = 1'b0; neg_b = 1'b1; end
        endcase
        if (full_step) begin
            mag_a = AMP_W'(AMP_MAX);
            mag_b = AMP_W'(AMP_MAX);
        end
    end

    assign amp_a      = mag_a;
    assign amp_b      = mag_b;
    assign coil_a_pos = drive_on && !neg_a && (mag_a != '0);
    assign coil_a_neg = drive_on &&  neg_a && (mag_a != '0);
    assign coil_b_pos = drive_on && !neg_b && (mag_b != '0);
    assign coil_b_neg = drive_on &&  neg_b && (mag_b != '0);
    assign quad_mon   = quad;
    assign off_origin = (frac != '0);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stp_pkg::*;
#(
    parameter int AMP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             step_in,
    input  logic             dir_fwd,
    input  logic [2:0]       mode_sel,
    input  logic             home_req,
    output logic             coil_a_pos,
    output logic             coil_a_neg,
    output logic             coil_b_pos,
    output logic             coil_b_neg,
    output logic [AMP_W-1:0] amp_a,
    output logic [AMP_W-1:0] amp_b,
    output logic [1:0]       quad_mon,
    output logic             off_origin
);
    seq_state_e state_q, state_d;
    idx_t       idx_q, idx_d;
    idx_t       step_amt, step_mask, idx_snap;
    logic [2:0] mode_q, mode_eff;
    gran_e      gran;
    logic       both_edges, full_step, step_pulse, drive_on;

    assign drive_on = (state_q == SEQ_RUN);
    assign mode_eff = drive_on ? mode_sel : mode_q;

    stp_mode_decode u_dec (
        .mode_sel   (mode_eff),
        .gran       (gran),
        .both_edges (both_edges),
        .full_step  (full_step)
    );

    stp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (step_in),
        .both_edges (both_edges),
        .pulse      (step_pulse)
    );

    always_comb begin
        unique case (state_q)
            SEQ_HOLD: state_d = run_en ? SEQ_RUN : SEQ_HOLD;
            SEQ_RUN:  state_d = run_en ? SEQ_RUN : SEQ_HOLD;
        endcase
    end

    assign step_amt  = idx_t'(1) << gran;
    assign step_mask = step_amt - idx_t'(1);
    assign idx_snap  = (idx_q + (step_amt >> 1)) & ~step_mask;

    always_comb begin
        idx_d = idx_q;
        unique case (state_q)
            SEQ_HOLD: idx_d = idx_q;
            SEQ_RUN: begin
                if (home_req)
                    idx_d = {idx_q[IDX_W-1 -: 2], {FRAC_W{1'b0}}};
                else if (step_pulse)
                    idx_d = dir_fwd ? (idx_snap + step_amt) : (idx_snap - step_amt);
                else
                    idx_d = idx_snap;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            idx_q   <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (drive_on) mode_q <= mode_sel;
        end
    end

    stp_wave_map #(.AMP_W(AMP_W)) u_wave (
        .idx        (idx_q),
        .full_step  (full_step),
        .drive_on   (drive_on),
        .coil_a_pos (coil_a_pos),
        .coil_a_neg (coil_a_neg),
        .coil_b_pos (coil_b_pos),
        .coil_b_neg (coil_b_neg),
        .amp_a      (amp_a),
        .amp_b      (amp_b),
        .quad_mon   (quad_mon),
        .off_origin (off_origin)
    );

    p_hold_coils_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !(coil_a_pos || coil_a_neg || coil_b_pos || coil_b_neg));

    p_hold_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD) |=> $stable(idx_q));

    p_home_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_on && home_req) |=> (!off_origin && quad_mon == $past(idx_q[IDX_W-1 -: 2])));

    p_grid_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |=> ((idx_q & $past(step_mask)) == '0));

    p_full_both_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_step |-> (amp_a == {AMP_W{1'b1}} && amp_b == {AMP_W{1'b1}}));
endmodule

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_fwd = 1'b1;
    logic [2:0] mode_sel = 3'b011;
    logic       home_req = 1'b0;
    logic       coil_a_pos, coil_a_neg, coil_b_pos, coil_b_neg;
    logic [7:0] amp_a, amp_b;
    logic [1:0] quad_mon;
    logic       off_origin;

    int n_chk = 0;
    int n_bad = 0;
    int m_idx = 0;
    int m_mode = 3;
    bit m_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stepper_phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .step_in(step_in),
        .dir_fwd(dir_fwd), .mode_sel(mode_sel), .home_req(home_req),
        .coil_a_pos(coil_a_pos), .coil_a_neg(coil_a_neg),
        .coil_b_pos(coil_b_pos), .coil_b_neg(coil_b_neg),
        .amp_a(amp_a), .amp_b(amp_b), .quad_mon(quad_mon), .off_origin(off_origin)
    );

    function automatic int qt(input int f);
        case (f)
            0, 1, 2: return 255;
            3:  return 245;
            4:  return 235;
            5:  return 224;
            6:  return 212;
            7:  return 197;
            8:  return 181;
            9:  return 161;
            10: return 140;
            11: return 121;
            12: return 102;
            13: return 77;
            14: return 51;
            15: return 26;
            default: return 0;
        endcase
    endfunction

    function automatic int inc_of(input int mode);
        case (mode)
            4: return 16;
            5: return 4;
            6: return 8;
            7: return 2;
            0: return 8;
            1: return 2;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [22:0] expect_vec(input int idx, input int mode, input bit on);
        int q; int f; int ma; int mb; bit na; bit nb;
        q = idx / 16;
        f = idx % 16;
        case (q)
            0: begin ma = qt(f);      mb = qt(16 - f); na = 0; nb = 0; end
            1: begin ma = qt(16 - f); mb = qt(f);      na = 1; nb = 0; end
            2: begin ma = qt(f);      mb = qt(16 - f); na = 1; nb = 1; end
            default: begin ma = qt(16 - f); mb = qt(f); na = 0; nb = 1; end
        endcase
        if (mode == 4) begin ma = 255; mb = 255; end
        return {on && !na && ma != 0, on && na && ma != 0,
                on && !nb && mb != 0, on && nb && mb != 0,
                8'(ma), 8'(mb), 2'(q), f != 0};
    endfunction

    task automatic check(input string tag);
        logic [22:0] act;
        logic [22:0] exp;
        act = {coil_a_pos, coil_a_neg, coil_b_pos, coil_b_neg, amp_a, amp_b, quad_mon, off_origin};
        exp = expect_vec(m_idx, m_mode, m_on);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s idx=%0d act=%h exp=%h", tag, m_idx, act, exp);
        end
    endtask

    task automatic toggle_step(input string tag);
        int inc;
        @(negedge clk) step_in = ~step_in;
        repeat (3) @(posedge clk);
        @(negedge clk);
        inc = inc_of(m_mode);
        if (m_on && (m_mode < 4 || step_in))
            m_idx = dir_fwd ? (m_idx + inc) % 64 : (m_idx + 64 - inc) % 64;
        check(tag);
    endtask

    task automatic set_mode(input int m, input string tag);
        int inc;
        @(negedge clk) mode_sel = 3'(m);
        m_mode = m;
        @(posedge clk);
        @(negedge clk);
        inc = inc_of(m);
        if (m_on) m_idx = ((m_idx + inc / 2) / inc * inc) % 64;
        check(tag);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_on = 1'b1;
        check("R1 first run cycle");
    endtask

    task automatic t_latency();
        @(negedge clk) step_in = ~step_in;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 before third edge");
        @(posedge clk);
        @(negedge clk);
        m_idx = 1;
        check("R2 on third edge");
    endtask

    task automatic t_walk();
        dir_fwd = 1'b1;
        for (int i = 0; i < 19; i++) toggle_step("R6 R7 R9 forward walk");
        dir_fwd = 1'b0;
        for (int i = 0; i < 21; i++) toggle_step("R5 R6 R7 reverse walk and wrap");
        dir_fwd = 1'b1;
        toggle_step("R5 forward wrap");
    endtask

    task automatic t_modes();
        int seq [8] = '{4, 5, 6, 7, 0, 1, 2, 3};
        dir_fwd = 1'b1;
        for (int i = 0; i < 8; i++) begin
            set_mode(seq[i], "R4 R11 mode entry");
            toggle_step("R3 R4 R8 edge and size");
            toggle_step("R3 R4 R8 edge and size");
        end
    endtask

    task automatic t_snap();
        set_mode(4, "R11 snap to full grid");
        set_mode(3, "R11 fine mode");
        dir_fwd = 1'b1;
        for (int i = 0; i < 5; i++) toggle_step("R11 setup");
        set_mode(6, "R11 round to nearest");
        set_mode(3, "R11 fine mode again");
        dir_fwd = 1'b0;
        for (int i = 0; i < 4; i++) toggle_step("R11 setup reverse");
        set_mode(6, "R11 tie rounds upward");
        set_mode(3, "R11 back to fine");
    endtask

    task automatic t_home();
        int n;
        dir_fwd = 1'b1;
        n = (21 - m_idx + 64) % 64;
        for (int i = 0; i < n; i++) toggle_step("R10 setup");
        @(negedge clk) home_req = 1'b1;
        @(posedge clk);
        @(negedge clk) home_req = 1'b0;
        m_idx = 16;
        check("R10 return to quadrant origin");
        for (int i = 0; i < 15; i++) toggle_step("R10 setup to 31");
        @(negedge clk) step_in = ~step_in;
        repeat (2) @(posedge clk);
        @(negedge clk) home_req = 1'b1;
        @(posedge clk);
        @(negedge clk) home_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_idx = 16;
        check("R10 return beats same-cycle step");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) toggle_step("R12 setup");
        @(negedge clk) run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_on = 1'b0;
        check("R12 coils cut");
        step_in = ~step_in;
        home_req = 1'b1;
        mode_sel = 3'b100;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R12 step, return and mode ignored");
        home_req = 1'b0;
        mode_sel = 3'b011;
        repeat (2) @(posedge clk);
        @(negedge clk) run_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_on = 1'b1;
        check("R12 resume with frozen position");
        toggle_step("R12 stepping after resume");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_walk();
        t_modes();
        t_snap();
        t_home();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog expired act=%0d exp=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule